// File: doc/BRIEF.md
# Command packet responder with seconds clock

This block sits behind a byte-serial handshake engine. When the engine has collected a whole packet from the host, it presents the packet here in one cycle. The responder reads the packet type and, for command packets, the command byte. It then builds the reply frame that the engine shifts back to the host. The frame is at most 16 bytes and comes with a length and a one-cycle valid strobe.

The responder also owns three pieces of state:
- a 32-bit count of seconds since the start of 1904, advanced by a one-second enable;
- an autopoll switch that emits periodic poll requests toward the peripheral bus;
- two request pulses, one for system power-off and one for system reset.

Packets for the peripheral bus are passed out on a side port. The responses that come back from the bus, and the results of polling, are turned into replies. The bus device protocol itself is outside this block.

Top module: `cmd_responder`

## Requirements
- R1: After reset, no reply, bus request or request pulse is active, autopoll is off, and the seconds value equals parameter RST_SECS (default 0).
- R2: The seconds value goes up by one for each cycle in which `sec_tick` is high and wraps from 0xFFFFFFFF to 0. A set-time load in the same cycle wins over the tick.
- R3: In a packet, byte 0 is the type and byte 1 is the command; type 1 marks a command packet.
  - Command 0x09 loads bytes 2..5 (most significant byte first) as the new seconds value and replies [1,0,0].
  - Command 0x03 replies with 7 bytes: [1,0,0] followed by the seconds value, most significant byte first. The value reported is the one held in the cycle the packet is presented.
- R4: Command 0x01 replies [1,arg], where arg is byte 2. Autopoll turns on when arg is nonzero and off when arg is zero.
- R5: While autopoll is on, `poll_req` pulses for one cycle every CLK_HZ/POLL_HZ cycles (50 per second by default). While it is off, `poll_req` stays low.
- R6: A poll result of length n>0 replies [0,0x40,data0..]. A result with n=0 produces no reply.
- R7: Commands 0x13, 0x14, 0x19 and 0x21 reply [1,0] and change nothing.
- R8: Command 0x0A replies [1,0] and then pulses `off_req` for one cycle, in the cycle after the reply. Command 0x11 does the same with `rst_req`.
- R9: The following produce no reply and no state change:
  - an unknown command;
  - packets of type 2, 3 or 4;
  - packets shorter than 2 bytes.
- R10: A type 0 packet of length L≥2 raises `bus_req_valid` one cycle later. The request carries packet bytes 1..L-1 as bytes 0..L-2 and has length L-1.
- R11: A bus response with nonzero `bus_rsp_err` replies [0,err,c], where c is byte 1 of the last forwarded packet. A response with zero err replies [0,0,data0..].
- R12: Every reply is valid in the cycle after its input. Priority is host packet, then bus response, then poll result, and a losing input in the same cycle is dropped. Frame byte i sits at bits 8i+7:8i, bytes at or beyond the length are zero, and payload lengths above 14 are cut to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Complete host packet present |
| pkt_data | input | 128 | Packet bytes, byte i at bits 8i+7:8i |
| pkt_len | input | 5 | Packet length in bytes |
| sec_tick | input | 1 | One-second enable |
| bus_rsp_valid | input | 1 | Peripheral bus response present |
| bus_rsp_err | input | 8 | Error code, 0 means success |
| bus_rsp_data | input | 112 | Response payload bytes |
| bus_rsp_len | input | 4 | Response payload length |
| poll_rsp_valid | input | 1 | Poll result present |
| poll_rsp_data | input | 112 | Poll payload bytes |
| poll_rsp_len | input | 4 | Poll payload length |
| rpl_valid | output | 1 | Reply frame strobe |
| rpl_data | output | 128 | Reply bytes |
| rpl_len | output | 5 | Reply length |
| bus_req_valid | output | 1 | Forwarded bus request strobe |
| bus_req_data | output | 120 | Forwarded request bytes |
| bus_req_len | output | 5 | Forwarded request length |
| poll_req | output | 1 | Periodic poll request |
| off_req | output | 1 | Power-off request pulse |
| rst_req | output | 1 | System reset request pulse |

## Verification
The assertions check several properties on every cycle:
- each power pulse lasts one cycle, follows a two-byte reply, and never coincides with the other pulse;
- `poll_req` only appears while autopoll is on;
- the seconds value either follows the tick or takes the loaded value;
- every reply length is legal;
- every bus request follows a type 0 packet.

Only the bench scenarios can show the byte contents of each framing, the big-endian time field, the wrap, the poll period, and the cases where an error code is echoed with its command byte. The same goes for the arbitration losers being dropped and for unknown commands staying silent.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    localparam int MAXB = 16;
    localparam int LENW = $clog2(MAXB + 1);
    localparam int PAYB = MAXB - 2;

    localparam logic [7:0] TYP_BUS  = 8'h00;
    localparam logic [7:0] TYP_CMD  = 8'h01;
    localparam logic [7:0] POLL_TAG = 8'h40;

    localparam logic [7:0] C_AUTOPOLL = 8'h01;
    localparam logic [7:0] C_GETTIME  = 8'h03;
    localparam logic [7:0] C_SETTIME  = 8'h09;
    localparam logic [7:0] C_POWEROFF = 8'h0A;
    localparam logic [7:0] C_SYSRESET = 8'h11;
    localparam logic [7:0] C_ACK_A    = 8'h13;
    localparam logic [7:0] C_ACK_B    = 8'h14;
    localparam logic [7:0] C_ACK_C    = 8'h19;
    localparam logic [7:0] C_ACK_D    = 8'h21;

    typedef logic [MAXB-1:0][7:0] frame_t;
    typedef logic [PAYB-1:0][7:0] pay_t;

    typedef struct packed {
        logic [LENW-1:0] len;
        frame_t          b;
    } reply_t;

    // Two header bytes followed by a clamped payload; unused bytes stay zero.
    function automatic reply_t frame_payload(input logic [7:0] h0, input logic [7:0] h1,
                                             input pay_t d, input logic [3:0] n);
        reply_t     r;
        logic [3:0] k;
        k = (n > 4'(PAYB)) ? 4'(PAYB) : n;
        r = '0;
        r.b[0] = h0;
        r.b[1] = h1;
        for (int i = 0; i < PAYB; i++) begin
            if (i < int'(k)) r.b[i+2] = d[i];
        end
        r.len = LENW'(k) + LENW'(2);
        return r;
    endfunction
endpackage

// File: rtl/cpr_seconds.sv
module cpr_seconds #(
    parameter logic [31:0] RST_SECS = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        load,
    input  logic [31:0] load_val,
    output logic [31:0] secs
);
    always_ff @(posedge clk) begin
        if (rst)       secs <= RST_SECS;
        else if (load) secs <= load_val;
        else if (tick) secs <= secs + 32'd1;
    end
endmodule

// File: rtl/cpr_poll_timer.sv
module cpr_poll_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic poll_req
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign poll_req = enable && (cnt == LAST);
endmodule

// File: rtl/cpr_decode.sv
module cpr_decode
    import cpr_pkg::*;
(
    input  logic                pkt_valid,
    input  logic [5:0][7:0]     hdr,
    input  logic [LENW-1:0]     pkt_len,
    input  logic [31:0]         secs,
    output reply_t              rpl,
    output logic                rpl_en,
    output logic                set_load,
    output logic [31:0]         set_val,
    output logic                ap_wr,
    output logic                ap_val,
    output logic                fwd_en,
    output logic                off_hit,
    output logic                rst_hit
);
    logic long_enough;
    assign long_enough = pkt_valid && (pkt_len >= LENW'(2));

    always_comb begin
        rpl      = '0;
        rpl_en   = 1'b0;
        set_load = 1'b0;
        set_val  = {hdr[2], hdr[3], hdr[4], hdr[5]};
        ap_wr    = 1'b0;
        ap_val   = (hdr[2] != 8'h00);
        fwd_en   = 1'b0;
        off_hit  = 1'b0;
        rst_hit  = 1'b0;
        if (long_enough && hdr[0] == TYP_BUS) begin
            fwd_en = 1'b1;
        end else if (long_enough && hdr[0] == TYP_CMD) begin
            rpl.b[0] = TYP_CMD;
            case (hdr[1])
                C_AUTOPOLL: begin
                    ap_wr    = 1'b1;
                    rpl.b[1] = hdr[2];
                    rpl.len  = LENW'(2);
                    rpl_en   = 1'b1;
                end
                C_SETTIME: begin
                    set_load = 1'b1;
                    rpl.len  = LENW'(3);
                    rpl_en   = 1'b1;
                end
                C_GETTIME: begin
                    rpl.b[3] = secs[31:24];
                    rpl.b[4] = secs[23:16];
                    rpl.b[5] = secs[15:8];
                    rpl.b[6] = secs[7:0];
                    rpl.len  = LENW'(7);
                    rpl_en   = 1'b1;
                end
                C_ACK_A, C_ACK_B, C_ACK_C, C_ACK_D: begin
                    rpl.len = LENW'(2);
                    rpl_en  = 1'b1;
                end
                C_POWEROFF: begin
                    off_hit = 1'b1;
                    rpl.len = LENW'(2);
                    rpl_en  = 1'b1;
                end
                C_SYSRESET: begin
                    rst_hit = 1'b1;
                    rpl.len = LENW'(2);
                    rpl_en  = 1'b1;
                end
                default: rpl = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
    import cpr_pkg::*;
#(
    parameter int          CLK_HZ   = 100_000_000,
    parameter int          POLL_HZ  = 50,
    parameter logic [31:0] RST_SECS = 32'd0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pkt_valid,
    input  logic [MAXB*8-1:0]     pkt_data,
    input  logic [LENW-1:0]       pkt_len,
    input  logic                  sec_tick,
    input  logic                  bus_rsp_valid,
    input  logic [7:0]            bus_rsp_err,
    input  logic [PAYB*8-1:0]     bus_rsp_data,
    input  logic [3:0]            bus_rsp_len,
    input  logic                  poll_rsp_valid,
    input  logic [PAYB*8-1:0]     poll_rsp_data,
    input  logic [3:0]            poll_rsp_len,
    output logic                  rpl_valid,
    output logic [MAXB*8-1:0]     rpl_data,
    output logic [LENW-1:0]       rpl_len,
    output logic                  bus_req_valid,
    output logic [(MAXB-1)*8-1:0] bus_req_data,
    output logic [LENW-1:0]       bus_req_len,
    output logic                  poll_req,
    output logic                  off_req,
    output logic                  rst_req
);
    localparam int POLL_PERIOD = CLK_HZ / POLL_HZ;

    frame_t pkt;
    assign pkt = frame_t'(pkt_data);

    reply_t      dec_rpl, nxt_rpl, rpl_q;
    logic        dec_en, nxt_en;
    logic        set_load, ap_wr, ap_val, fwd_en, off_hit, rst_hit;
    logic [31:0] set_val, secs;
    logic        autopoll_q;
    logic [7:0]  last_cmd_q;
    logic        off_p1, rst_p1;
    logic [MAXB-2:0][7:0] breq_q;

    cpr_decode u_dec (
        .pkt_valid (pkt_valid),
        .hdr       (pkt[5:0]),
        .pkt_len   (pkt_len),
        .secs      (secs),
        .rpl       (dec_rpl),
        .rpl_en    (dec_en),
        .set_load  (set_load),
        .set_val   (set_val),
        .ap_wr     (ap_wr),
        .ap_val    (ap_val),
        .fwd_en    (fwd_en),
        .off_hit   (off_hit),
        .rst_hit   (rst_hit)
    );

    cpr_seconds #(.RST_SECS(RST_SECS)) u_secs (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .load     (set_load),
        .load_val (set_val),
        .secs     (secs)
    );

    cpr_poll_timer #(.PERIOD(POLL_PERIOD)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .enable   (autopoll_q),
        .poll_req (poll_req)
    );

    // Reply source arbitration: host packet, then bus response, then poll result.
    always_comb begin
        nxt_rpl = dec_rpl;
        nxt_en  = dec_en;
        if (!dec_en) begin
            if (bus_rsp_valid) begin
                nxt_en = 1'b1;
                if (bus_rsp_err != 8'h00) begin
                    nxt_rpl      = '0;
                    nxt_rpl.b[0] = TYP_BUS;
                    nxt_rpl.b[1] = bus_rsp_err;
                    nxt_rpl.b[2] = last_cmd_q;
                    nxt_rpl.len  = LENW'(3);
                end else begin
                    nxt_rpl = frame_payload(TYP_BUS, 8'h00, pay_t'(bus_rsp_data), bus_rsp_len);
                end
            end else if (poll_rsp_valid && poll_rsp_len != 4'd0) begin
                nxt_en  = 1'b1;
                nxt_rpl = frame_payload(TYP_BUS, POLL_TAG, pay_t'(poll_rsp_data), poll_rsp_len);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpl_q         <= '0;
            rpl_valid     <= 1'b0;
            autopoll_q    <= 1'b0;
            last_cmd_q    <= 8'h00;
            bus_req_valid <= 1'b0;
            breq_q        <= '0;
            bus_req_len   <= '0;
            off_p1        <= 1'b0;
            off_req       <= 1'b0;
            rst_p1        <= 1'b0;
            rst_req       <= 1'b0;
        end else begin
            rpl_valid <= nxt_en;
            if (nxt_en) rpl_q <= nxt_rpl;
            if (ap_wr) autopoll_q <= ap_val;
            bus_req_valid <= fwd_en;
            if (fwd_en) begin
                last_cmd_q  <= pkt[1];
                bus_req_len <= pkt_len - LENW'(1);
                for (int i = 0; i < MAXB - 1; i++) begin
                    breq_q[i] <= (i < int'(pkt_len) - 1) ? pkt[i+1] : 8'h00;
                end
            end
            off_p1  <= off_hit;
            off_req <= off_p1;
            rst_p1  <= rst_hit;
            rst_req <= rst_p1;
        end
    end

    assign rpl_data     = rpl_q.b;
    assign rpl_len      = rpl_q.len;
    assign bus_req_data = breq_q;
endmodule

// File: rtl/cpr_chk.sv
module cpr_chk (
    input logic        clk,
    input logic        rst,
    input logic        rpl_valid,
    input logic [4:0]  rpl_len,
    input logic        off_req,
    input logic        rst_req,
    input logic        poll_req,
    input logic        ap_on,
    input logic        sec_tick,
    input logic        set_load,
    input logic [31:0] set_val,
    input logic [31:0] secs,
    input logic        bus_req_valid,
    input logic        pkt_valid,
    input logic [7:0]  pkt_type
);
    // R8
    off_after_reply_chk: assert property (@(posedge clk) disable iff (rst)
        off_req |-> ($past(rpl_valid) && $past(rpl_len) == 5'd2));
    // R8
    rst_after_reply_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> ($past(rpl_valid) && $past(rpl_len) == 5'd2));
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (off_req || rst_req) |=> !(off_req || rst_req));
    // R8
    exclusive_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(off_req && rst_req));
    // R5
    poll_when_on_chk: assert property (@(posedge clk) disable iff (rst)
        poll_req |-> ap_on);
    // R2
    tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sec_tick) && !$past(set_load)) |-> secs == $past(secs) + 32'd1);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sec_tick) && !$past(set_load)) |-> secs == $past(secs));
    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_load |=> secs == $past(set_val));
    // R12
    reply_len_chk: assert property (@(posedge clk) disable iff (rst)
        rpl_valid |-> (rpl_len >= 5'd2 && rpl_len <= 5'd16));
    // R10
    fwd_source_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> ($past(pkt_valid) && $past(pkt_type) == 8'h00));
endmodule

bind cmd_responder cpr_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rpl_valid     (rpl_valid),
    .rpl_len       (rpl_len),
    .off_req       (off_req),
    .rst_req       (rst_req),
    .poll_req      (poll_req),
    .ap_on         (autopoll_q),
    .sec_tick      (sec_tick),
    .set_load      (set_load),
    .set_val       (set_val),
    .secs          (secs),
    .bus_req_valid (bus_req_valid),
    .pkt_valid     (pkt_valid),
    .pkt_type      (pkt_data[7:0])
);

// File: tb/sim_cmd_responder.sv
`timescale 1ns/1ps
module sim_cmd_responder;
    localparam int PERIOD_EXP = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pkt_valid = 0;
    logic [127:0] pkt_data = '0;
    logic [4:0]   pkt_len = '0;
    logic         sec_tick = 0;
    logic         bus_rsp_valid = 0;
    logic [7:0]   bus_rsp_err = '0;
    logic [111:0] bus_rsp_data = '0;
    logic [3:0]   bus_rsp_len = '0;
    logic         poll_rsp_valid = 0;
    logic [111:0] poll_rsp_data = '0;
    logic [3:0]   poll_rsp_len = '0;
    logic         rpl_valid;
    logic [127:0] rpl_data;
    logic [4:0]   rpl_len;
    logic         bus_req_valid;
    logic [119:0] bus_req_data;
    logic [4:0]   bus_req_len;
    logic         poll_req, off_req, rst_req;

    cmd_responder #(.CLK_HZ(1000), .POLL_HZ(50), .RST_SECS(32'd0)) u0 (.*);

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0, replies_seen = 0, replies_pushed = 0;
    int last_rpl_cyc = 0, off_cnt = 0, rst_cnt = 0, off_gap = 0, rst_gap = 0;
    int poll_cnt = 0, last_poll_cyc = -1, poll_int = 0;

    typedef struct { logic [127:0] d; logic [4:0] n; string tag; } exp_t;
    exp_t q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [127:0] pk(input logic [7:0] b0 = 0, input logic [7:0] b1 = 0,
        input logic [7:0] b2 = 0, input logic [7:0] b3 = 0, input logic [7:0] b4 = 0,
        input logic [7:0] b5 = 0, input logic [7:0] b6 = 0);
        logic [127:0] r;
        r = '0;
        r[55:0] = {b6, b5, b4, b3, b2, b1, b0};
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_rpl(input logic [127:0] d, input logic [4:0] n, input string tag);
        exp_t e;
        e.d = d; e.n = n; e.tag = tag;
        q.push_back(e);
        replies_pushed++;
    endtask

    // Monitor: pops the scoreboard on every reply and tracks pulses.
    always @(negedge clk) begin
        if (!rst) begin
            if (rpl_valid) begin
                replies_seen++;
                last_rpl_cyc = cyc;
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected reply", {rpl_data}, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(rpl_len == e.n && rpl_data == e.d, e.tag, {rpl_len, rpl_data[122:0]},
                        {e.n, e.d[122:0]});
                end
            end
            if (off_req) begin off_cnt++; off_gap = cyc - last_rpl_cyc; end
            if (rst_req) begin rst_cnt++; rst_gap = cyc - last_rpl_cyc; end
            if (poll_req) begin
                if (last_poll_cyc >= 0) poll_int = cyc - last_poll_cyc;
                last_poll_cyc = cyc;
                poll_cnt++;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        pkt_valid = 0; sec_tick = 0; bus_rsp_valid = 0; poll_rsp_valid = 0;
    endtask

    task automatic set_pkt(input logic [127:0] d, input int n);
        pkt_valid = 1; pkt_data = d; pkt_len = 5'(n);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_up();
        chk(q.size() == 0 && replies_seen == replies_pushed, "R12 reply count",
            128'(replies_seen), 128'(replies_pushed));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(4);
        rst = 0;
        @(negedge clk);
        chk(!rpl_valid && !off_req && !rst_req && !poll_req && !bus_req_valid, "R1 reset outputs",
            {rpl_valid, off_req, rst_req, poll_req, bus_req_valid}, '0);
        @(posedge clk); #1;
        // R1 seconds value at reset
        set_pkt(pk(1, 8'h03), 2); expect_rpl(pk(1, 0, 0, 0, 0, 0, 0), 7, "R1 reset seconds"); step();
        // R2 ticks
        for (int i = 0; i < 3; i++) begin sec_tick = 1; step(); end
        set_pkt(pk(1, 8'h03), 2); expect_rpl(pk(1, 0, 0, 0, 0, 0, 3), 7, "R2 three ticks"); step();
        // R3 set-time then wrap (R2)
        set_pkt(pk(1, 8'h09, 8'hFF, 8'hFF, 8'hFF, 8'hFE), 6); expect_rpl(pk(1, 0, 0), 3, "R3 set reply"); step();
        for (int i = 0; i < 3; i++) begin sec_tick = 1; step(); end
        set_pkt(pk(1, 8'h03), 2); expect_rpl(pk(1, 0, 0, 0, 0, 0, 1), 7, "R2 wrap"); step();
        // R2 load wins over tick
        set_pkt(pk(1, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78), 6); sec_tick = 1;
        expect_rpl(pk(1, 0, 0), 3, "R3 set reply"); step();
        // R3 get-time reports value before a same-cycle tick
        set_pkt(pk(1, 8'h03), 2); sec_tick = 1;
        expect_rpl(pk(1, 0, 0, 8'h12, 8'h34, 8'h56, 8'h78), 7, "R2 load beats tick"); step();
        set_pkt(pk(1, 8'h03), 2); expect_rpl(pk(1, 0, 0, 8'h12, 8'h34, 8'h56, 8'h79), 7, "R3 big-endian"); step();
        // R7 acknowledged commands
        set_pkt(pk(1, 8'h13), 2); expect_rpl(pk(1, 0), 2, "R7 ack 13"); step();
        set_pkt(pk(1, 8'h14), 2); expect_rpl(pk(1, 0), 2, "R7 ack 14"); step();
        set_pkt(pk(1, 8'h19), 2); expect_rpl(pk(1, 0), 2, "R7 ack 19"); step();
        set_pkt(pk(1, 8'h21, 8'h09), 3); expect_rpl(pk(1, 0), 2, "R7 ack 21"); step();
        // R9 silent packets
        set_pkt(pk(1, 8'h55), 2); step();
        set_pkt(pk(2, 8'h09, 1, 1, 1, 1), 6); step();
        set_pkt(pk(3, 8'h03), 2); step();
        set_pkt(pk(4, 8'h0A), 2); step();
        set_pkt(pk(1, 8'h09), 1); step();
        idle(3);
        chk(replies_seen == replies_pushed && off_cnt == 0, "R9 no reply", 128'(replies_seen), 128'(replies_pushed));
        set_pkt(pk(1, 8'h03), 2); expect_rpl(pk(1, 0, 0, 8'h12, 8'h34, 8'h56, 8'h79), 7, "R9 time untouched"); step();
        // R8 power-off and reset requests
        set_pkt(pk(1, 8'h0A), 2); expect_rpl(pk(1, 0), 2, "R8 poweroff reply"); step();
        idle(4);
        chk(off_cnt == 1 && rst_cnt == 0 && off_gap == 1, "R8 off pulse", 128'({off_cnt, off_gap}), 128'({32'd1, 32'd1}));
        set_pkt(pk(1, 8'h11), 2); expect_rpl(pk(1, 0), 2, "R8 reset reply"); step();
        idle(4);
        chk(rst_cnt == 1 && off_cnt == 1 && rst_gap == 1, "R8 rst pulse", 128'({rst_cnt, rst_gap}), 128'({32'd1, 32'd1}));
        // R10 forwarding
        set_pkt(pk(0, 8'h2C, 8'h55, 8'h66), 4); step();
        chk(bus_req_valid && bus_req_len == 5'd3 && bus_req_data == 120'h66552C, "R10 forward",
            128'({bus_req_len, bus_req_data}), 128'({5'd3, 120'h66552C}));
        step();
        chk(!bus_req_valid, "R10 one-cycle strobe", 128'(bus_req_valid), '0);
        // R11 bus responses
        bus_rsp_valid = 1; bus_rsp_err = 8'h03; bus_rsp_data = '0; bus_rsp_len = 0;
        expect_rpl(pk(0, 8'h03, 8'h2C), 3, "R11 error echo"); step();
        bus_rsp_valid = 1; bus_rsp_err = 0; bus_rsp_data = 112'hCC_BBAA; bus_rsp_len = 2;
        expect_rpl(pk(0, 0, 8'hAA, 8'hBB), 4, "R11 success data"); step();
        // R12 priority: host packet beats bus response
        set_pkt(pk(1, 8'h13), 2); bus_rsp_valid = 1; bus_rsp_err = 8'h07;
        expect_rpl(pk(1, 0), 2, "R12 priority"); step();
        idle(2);
        // R4 / R5 autopoll
        set_pkt(pk(1, 8'h01, 8'h07), 3); expect_rpl(pk(1, 8'h07), 2, "R4 autopoll on"); step();
        idle(70);
        chk(poll_cnt >= 3 && poll_int == PERIOD_EXP, "R5 poll period", 128'(poll_int), 128'(PERIOD_EXP));
        // R6 poll results
        poll_rsp_valid = 1; poll_rsp_data = 112'h22_11; poll_rsp_len = 2;
        expect_rpl(pk(0, 8'h40, 8'h11, 8'h22), 4, "R6 poll data"); step();
        poll_rsp_valid = 1; poll_rsp_len = 0; step();
        set_pkt(pk(1, 8'h01, 8'h00), 3); expect_rpl(pk(1, 0), 2, "R4 autopoll off"); step();
        idle(2);
        poll_cnt = 0;
        idle(60);
        chk(poll_cnt == 0, "R5 no poll when off", 128'(poll_cnt), '0);
        idle(2);
        finish_up();
    end
endmodule